// File: doc/BRIEF.md
# Halt-and-Sweep Debug Mode Engine

This block models the hidden test mode of a small 8-bit processor core. It watches the opcode fetch interface. When a fetched opcode is one of three trigger codes, the core is locked out of normal work. A long fixed latency follows, and then the engine drives a free-running address count onto the 16-bit address bus. The trigger opcode sets how fast the count steps. Once the mode is entered, only a hard reset brings the engine back.

While the engine is in normal operation, it also presents the interrupt vector address for one cycle whenever an interrupt request is seen. This makes the point at which interrupts stop being honoured visible at the ports. Real instruction execution, data-bus traffic and multi-phase clocking are not modelled.

The block is meant as a behavioural stand-in for a processor socket in a bench or a tester fabric. The latency is a parameter in clock cycles, so a simulation can shorten the 64 ms wait to a few cycles.

Top module: `halt_sweep_engine`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `halted_o` is 0, `addr_vld_o` is 0 and `addr_o` is 0x0000.
- R2: A fetch (`fetch_i`=1) of opcode 0x9D, 0xDD or 0xFD in normal operation sets `halted_o` on that clock edge, and it stays 1 until reset.
- R3: No other opcode triggers the mode. This includes 0x14 and 0x15, which are plain two-cycle instructions here: `halted_o` stays 0.
- R4: From the trigger edge, `addr_vld_o` stays 0 and `addr_o` holds 0x0000 for LATENCY cycles. On exactly the LATENCY-th edge after the trigger, `addr_vld_o` rises with `addr_o` = 0x0000.
- R5: After a 0x9D or 0xDD trigger, the sweep advances by one on every clock, so bit 0 of the address has a period of two clocks.
- R6: After a 0xFD trigger, the sweep advances on every second clock, starting with a second cycle at 0x0000, so bit 0 of the address has a period of four clocks.
- R7: The sweep wraps from 0xFFFF to 0x0000 and keeps counting; `addr_vld_o` stays 1 until reset.
- R8: Fetch strobes that arrive after the trigger, including further trigger opcodes, are ignored: they neither restart the latency nor change the rate.
- R9: In normal operation, a request on `nmi_i` or `irq_i` drives `addr_vld_o`=1 on the next cycle with vector 0xFFFC (NMI, which has priority) or 0xFFF8 (IRQ). After the trigger, both requests have no effect on any output.
- R10: Asserting reset from any halted state, whether waiting or sweeping, returns all outputs to the R1 values, and the engine then reacts to opcodes again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low (the hard reset) |
| fetch_i | input | 1 | Opcode fetch strobe |
| opcode_i | input | 8 | Opcode byte sampled with `fetch_i` |
| irq_i | input | 1 | Maskable interrupt request |
| nmi_i | input | 1 | Non-maskable interrupt request |
| addr_o | output | 16 | Address bus |
| halted_o | output | 1 | Core locked in the test mode |
| addr_vld_o | output | 1 | Address bus carries a driven address |

## Verification
The hardest states to reach are the counter wrap at 0xFFFF and the slow sweep after a mid-mode retrigger. A full fast sweep takes more than 65,536 clocks, and the slow rate is only visible if a later 0x9D fetch is shown not to speed it up. The bench therefore runs one complete fast sweep across the wrap with a shortened latency. It issues 0x9D fetches together with interrupt requests during both the wait and the slow sweep, and it compares every cycle against a cycles-since-trigger model.

// File: rtl/hse_pkg.sv
package hse_pkg;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_WAIT  = 2'd1,
      ST_SWEEP = 2'd2
   } hse_state_e;

   typedef enum logic {
      RATE_FULL = 1'b0,
      RATE_DIV  = 1'b1
   } hse_rate_e;

   typedef struct packed {
      logic      hit;
      hse_rate_e rate;
   } hse_trig_t;

endpackage

// File: rtl/hse_trigger_dec.sv
module hse_trigger_dec
   import hse_pkg::*;
#(
   parameter logic [7:0] OP_FAST_A = 8'h9D,
   parameter logic [7:0] OP_FAST_B = 8'hDD,
   parameter logic [7:0] OP_SLOW   = 8'hFD
) (
   input  logic [7:0] opcode_i,
   output hse_trig_t  trig_o
);

   localparam int NCODE = 3;
   localparam logic [NCODE-1:0][7:0] CODES = {OP_SLOW, OP_FAST_B, OP_FAST_A};
   localparam logic [NCODE-1:0]      SLOWS = 3'b100;

   logic [NCODE-1:0] match;

   for (genvar g = 0; g < NCODE; g++) begin : g_cmp
      assign match[g] = (opcode_i == CODES[g]);
   end

   always_comb begin
      trig_o.hit  = |match;
      trig_o.rate = (|(match & SLOWS)) ? RATE_DIV : RATE_FULL;
   end

endmodule

// File: rtl/hse_ctrl.sv
module hse_ctrl
   import hse_pkg::*;
#(
   parameter int              LATENCY = 64000,
   parameter int              ADDR_W  = 16,
   parameter logic [ADDR_W-1:0] VEC_IRQ = 16'hFFF8,
   parameter logic [ADDR_W-1:0] VEC_NMI = 16'hFFFC
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              fetch_i,
   input  hse_trig_t         trig_i,
   input  logic              irq_i,
   input  logic              nmi_i,
   output hse_state_e        state_o,
   output hse_rate_e         rate_o,
   output logic              vec_vld_o,
   output logic [ADDR_W-1:0] vec_addr_o
);

   localparam int CW = (LATENCY < 2) ? 1 : $clog2(LATENCY);
   localparam logic [CW-1:0] LAST = CW'(LATENCY - 1);

   hse_state_e  state_q;
   hse_rate_e   rate_q;
   logic [CW-1:0] wait_q;
   logic        vec_vld_q;
   logic [ADDR_W-1:0] vec_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= ST_RUN;
         rate_q    <= RATE_FULL;
         wait_q    <= '0;
         vec_vld_q <= 1'b0;
         vec_q     <= '0;
      end else begin
         unique case (state_q)
            ST_RUN: begin
               if (fetch_i && trig_i.hit) begin
                  state_q   <= ST_WAIT;
                  rate_q    <= trig_i.rate;
                  wait_q    <= '0;
                  vec_vld_q <= 1'b0;
                  vec_q     <= '0;
               end else if (nmi_i) begin
                  vec_vld_q <= 1'b1;
                  vec_q     <= VEC_NMI;
               end else if (irq_i) begin
                  vec_vld_q <= 1'b1;
                  vec_q     <= VEC_IRQ;
               end else begin
                  vec_vld_q <= 1'b0;
                  vec_q     <= '0;
               end
            end
            ST_WAIT: begin
               if (wait_q == LAST) begin
                  state_q <= ST_SWEEP;
               end else begin
                  wait_q <= wait_q + 1'b1;
               end
            end
            ST_SWEEP: state_q <= ST_SWEEP;
            default:  state_q <= ST_RUN;
         endcase
      end
   end

   assign state_o    = state_q;
   assign rate_o     = rate_q;
   assign vec_vld_o  = vec_vld_q;
   assign vec_addr_o = vec_q;

endmodule

// File: rtl/hse_sweep.sv
module hse_sweep
   import hse_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int SLOW_DIV = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_i,
   input  hse_rate_e         rate_i,
   output logic [ADDR_W-1:0] addr_o
);

   logic              step;
   logic [ADDR_W-1:0] addr_q;

   if (SLOW_DIV == 1) begin : g_nodiv
      assign step = run_i;
   end else begin : g_div
      localparam int PW = $clog2(SLOW_DIV);
      localparam logic [PW-1:0] PLAST = PW'(SLOW_DIV - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            pre_q <= '0;
         end else if (!run_i) begin
            pre_q <= '0;
         end else if (pre_q == PLAST) begin
            pre_q <= '0;
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end

      assign step = run_i && ((rate_i == RATE_FULL) || (pre_q == PLAST));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         addr_q <= '0;
      end else if (!run_i) begin
         addr_q <= '0;
      end else if (step) begin
         addr_q <= addr_q + 1'b1;
      end
   end

   assign addr_o = addr_q;

endmodule

// File: rtl/halt_sweep_engine.sv
module halt_sweep_engine
   import hse_pkg::*;
#(
   parameter int              ADDR_W    = 16,
   parameter int              LATENCY   = 64000,
   parameter int              SLOW_DIV  = 2,
   parameter logic [7:0]      OP_FAST_A = 8'h9D,
   parameter logic [7:0]      OP_FAST_B = 8'hDD,
   parameter logic [7:0]      OP_SLOW   = 8'hFD,
   parameter logic [ADDR_W-1:0] VEC_IRQ = 16'hFFF8,
   parameter logic [ADDR_W-1:0] VEC_NMI = 16'hFFFC
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              fetch_i,
   input  logic [7:0]        opcode_i,
   input  logic              irq_i,
   input  logic              nmi_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              halted_o,
   output logic              addr_vld_o
);

   if (ADDR_W < 4) begin : g_bad_w
      $error("ADDR_W must be at least 4");
   end
   if (LATENCY < 1) begin : g_bad_lat
      $error("LATENCY must be at least 1");
   end
   if (SLOW_DIV < 1) begin : g_bad_div
      $error("SLOW_DIV must be at least 1");
   end

   hse_trig_t         trig;
   hse_state_e        state;
   hse_rate_e         rate;
   logic              vec_vld;
   logic [ADDR_W-1:0] vec_addr;
   logic [ADDR_W-1:0] sweep_addr;
   logic              sweeping;

   hse_trigger_dec #(
      .OP_FAST_A (OP_FAST_A),
      .OP_FAST_B (OP_FAST_B),
      .OP_SLOW   (OP_SLOW)
   ) dec_i (
      .opcode_i (opcode_i),
      .trig_o   (trig)
   );

   hse_ctrl #(
      .LATENCY (LATENCY),
      .ADDR_W  (ADDR_W),
      .VEC_IRQ (VEC_IRQ),
      .VEC_NMI (VEC_NMI)
   ) ctrl_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .fetch_i    (fetch_i),
      .trig_i     (trig),
      .irq_i      (irq_i),
      .nmi_i      (nmi_i),
      .state_o    (state),
      .rate_o     (rate),
      .vec_vld_o  (vec_vld),
      .vec_addr_o (vec_addr)
   );

   assign sweeping = (state == ST_SWEEP);

   hse_sweep #(
      .ADDR_W   (ADDR_W),
      .SLOW_DIV (SLOW_DIV)
   ) sweep_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (sweeping),
      .rate_i (rate),
      .addr_o (sweep_addr)
   );

   assign halted_o   = (state != ST_RUN);
   assign addr_vld_o = sweeping | vec_vld;
   assign addr_o     = sweeping ? sweep_addr : vec_addr;

endmodule

// File: rtl/hse_checker.sv
module hse_checker #(
   parameter int              ADDR_W    = 16,
   parameter logic [7:0]      OP_FAST_A = 8'h9D,
   parameter logic [ADDR_W-1:0] VEC_IRQ = 16'hFFF8,
   parameter logic [ADDR_W-1:0] VEC_NMI = 16'hFFFC
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              fetch_i,
   input logic [7:0]        opcode_i,
   input logic              irq_i,
   input logic              nmi_i,
   input logic [ADDR_W-1:0] addr_o,
   input logic              halted_o,
   input logic              addr_vld_o
);

   a_r2_trigger_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!halted_o && fetch_i && opcode_i == OP_FAST_A) |=> halted_o);

   a_r2_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      halted_o |=> halted_o);

   a_r3_plain_ops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!halted_o && fetch_i && (opcode_i == 8'h14 || opcode_i == 8'h15)) |=> !halted_o);

   a_r4_hold_in_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (halted_o && !addr_vld_o) |-> addr_o == '0);

   a_r4_start_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (halted_o && $rose(addr_vld_o)) |-> addr_o == '0);

   a_r7_valid_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (halted_o && addr_vld_o) |=> addr_vld_o);

   a_r5_step_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (halted_o && addr_vld_o && $past(halted_o && addr_vld_o)) |->
      (addr_o == $past(addr_o) || addr_o == ADDR_W'($past(addr_o) + 1'b1)));

   a_r9_vector_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!halted_o && addr_vld_o) |-> (addr_o == VEC_IRQ || addr_o == VEC_NMI));

   a_r9_nmi_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!halted_o && !fetch_i && nmi_i) |=> (addr_vld_o && addr_o == VEC_NMI));

endmodule

bind halt_sweep_engine hse_checker #(
   .ADDR_W    (ADDR_W),
   .OP_FAST_A (OP_FAST_A),
   .VEC_IRQ   (VEC_IRQ),
   .VEC_NMI   (VEC_NMI)
) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .fetch_i    (fetch_i),
   .opcode_i   (opcode_i),
   .irq_i      (irq_i),
   .nmi_i      (nmi_i),
   .addr_o     (addr_o),
   .halted_o   (halted_o),
   .addr_vld_o (addr_vld_o)
);

// File: tb/halt_sweep_engine_tb_top.sv
module halt_sweep_engine_tb_top;

   localparam int LAT = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch = 1'b0;
   logic [7:0]  opcode = 8'h00;
   logic        irq = 1'b0;
   logic        nmi = 1'b0;
   logic [15:0] addr;
   logic        halted;
   logic        vld;

   int vectors = 0;
   int fails = 0;
   int cycles = 0;
   string cur_tag = "R1";

   logic        obs_vld;
   logic [15:0] obs_addr;
   logic        obs_halted;

   always #10 clk = ~clk;

   halt_sweep_engine #(.LATENCY(LAT)) dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .fetch_i    (fetch),
      .opcode_i   (opcode),
      .irq_i      (irq),
      .nmi_i      (nmi),
      .addr_o     (addr),
      .halted_o   (halted),
      .addr_vld_o (vld)
   );

   // Behavioural reference: cycles elapsed since the trigger fetch.
   logic        m_h;
   longint      m_cyc;
   logic        m_slow;
   logic        m_vv;
   logic [15:0] m_vec;

   function automatic logic is_trig(input logic [7:0] op);
      return op == 8'h9D || op == 8'hDD || op == 8'hFD;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_h <= 1'b0; m_cyc <= 0; m_slow <= 1'b0; m_vv <= 1'b0; m_vec <= 16'h0;
      end else if (!m_h) begin
         if (fetch && is_trig(opcode)) begin
            m_h <= 1'b1; m_cyc <= 0; m_slow <= (opcode == 8'hFD); m_vv <= 1'b0;
         end else if (nmi) begin
            m_vv <= 1'b1; m_vec <= 16'hFFFC;
         end else if (irq) begin
            m_vv <= 1'b1; m_vec <= 16'hFFF8;
         end else begin
            m_vv <= 1'b0; m_vec <= 16'h0;
         end
      end else begin
         m_cyc <= m_cyc + 1;
      end
   end

   task automatic fail_line(input string tag, input string what,
                            input longint act, input longint exp);
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
   endtask

   task automatic compare_all();
      logic        e_vld;
      logic [15:0] e_addr;
      longint      n;
      if (m_h) begin
         e_vld = (m_cyc >= LAT);
         if (e_vld) begin
            n = m_cyc - LAT;
            if (m_slow) n = n / 2;
            e_addr = 16'(n % 65536);
         end else begin
            e_addr = 16'h0;
         end
      end else begin
         e_vld  = m_vv;
         e_addr = m_vv ? m_vec : 16'h0;
      end
      vectors++;
      if (halted !== m_h)   fail_line(cur_tag, "halted", halted, m_h);
      if (vld !== e_vld)    fail_line(cur_tag, "addr_vld", vld, e_vld);
      if (addr !== e_addr)  fail_line(cur_tag, "addr", addr, e_addr);
      obs_vld = vld; obs_addr = addr; obs_halted = halted;
   endtask

   task automatic step(input logic f, input logic [7:0] op,
                       input logic ir, input logic nm);
      @(negedge clk);
      compare_all();
      fetch = f; opcode = op; irq = ir; nmi = nm;
   endtask

   task automatic idle();
      step(1'b0, 8'h00, 1'b0, 1'b0);
   endtask

   task automatic expect_bit(input string tag, input string what,
                             input logic act, input logic exp);
      vectors++;
      if (act !== exp) fail_line(tag, what, act, exp);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      fetch = 1'b0; irq = 1'b0; nmi = 1'b0;
      #1;
      // R10 / R1: outputs cleared while reset is held
      expect_bit(cur_tag, "halted in reset", halted, 1'b0);
      expect_bit(cur_tag, "vld in reset", vld, 1'b0);
      expect_bit(cur_tag, "addr zero in reset", addr == 16'h0, 1'b1);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Trigger, then check latency edge and the A0 pattern over 8 sweep cycles.
   task automatic sweep_run(input logic [7:0] op, input logic slow, input logic disturb);
      logic a0_exp;
      step(1'b1, op, 1'b0, 1'b0);
      for (int j = 0; j < LAT + 8; j++) begin
         if (disturb) step(1'b1, 8'h9D, j[0], j[1]);   // R8 R9 stimulus
         else idle();
         if (j < LAT) begin
            cur_tag = "R4";
            expect_bit("R4", "vld during wait", obs_vld, 1'b0);
         end else begin
            a0_exp = slow ? 1'((j - LAT) / 2) : 1'(j - LAT);
            cur_tag = slow ? "R6" : "R5";
            expect_bit(slow ? "R6" : "R5", "A0 pattern", obs_addr[0], a0_exp);
            if (j == LAT) expect_bit("R4", "sweep starts at 0", obs_vld && obs_addr == 16'h0, 1'b1);
         end
      end
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 190000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<190000 cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
         end
      end
   end

   initial begin : stim
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      cur_tag = "R1";
      idle();
      expect_bit("R1", "reset state", obs_halted | obs_vld | (|obs_addr), 1'b0);

      // R3: every non-trigger opcode, incl. 0x14 / 0x15
      cur_tag = "R3";
      for (int op = 0; op < 256; op++) begin
         if (!is_trig(8'(op))) step(1'b1, 8'(op), 1'b0, 1'b0);
      end
      step(1'b1, 8'h14, 1'b0, 1'b0);
      step(1'b1, 8'h15, 1'b0, 1'b0);
      idle();
      expect_bit("R3", "0x14/0x15 no trigger", obs_halted, 1'b0);

      // R9: vectors in normal operation, NMI priority
      cur_tag = "R9";
      step(1'b0, 8'h00, 1'b1, 1'b0);
      step(1'b0, 8'h00, 1'b1, 1'b1);
      idle();
      expect_bit("R9", "NMI vector wins", obs_vld && obs_addr == 16'hFFFC, 1'b1);
      idle();

      // R2 R4 R5: fast trigger 0x9D, undisturbed
      cur_tag = "R2";
      sweep_run(8'h9D, 1'b0, 1'b0);
      expect_bit("R2", "halted stays", obs_halted, 1'b1);
      cur_tag = "R10";
      do_reset();
      idle();

      // R8 R9: 0xDD with retriggers and interrupts throughout
      cur_tag = "R8";
      sweep_run(8'hDD, 1'b0, 1'b1);
      cur_tag = "R10";
      do_reset();
      idle();
      expect_bit("R10", "normal after reset", obs_halted, 1'b0);

      // R6 R8: slow trigger, later 0x9D fetches must not speed it up
      sweep_run(8'hFD, 1'b1, 1'b1);
      cur_tag = "R8";
      for (int j = 0; j < 40; j++) step(1'b1, 8'h9D, 1'b1, 1'b1);
      cur_tag = "R10";
      do_reset();
      idle();

      // R7: full fast sweep across the wrap
      cur_tag = "R7";
      step(1'b1, 8'h9D, 1'b0, 1'b0);
      for (int j = 0; j < LAT + 65540; j++) begin
         idle();
         if (j == LAT + 65535) expect_bit("R7", "reaches FFFF", obs_addr == 16'hFFFF, 1'b1);
         if (j == LAT + 65536) expect_bit("R7", "wraps to 0000", obs_vld && obs_addr == 16'h0, 1'b1);
      end
      cur_tag = "R10";
      do_reset();
      idle();

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule